// File: doc/BRIEF.md
# Dual-Bank Reloadable FIR Filter

This block is a single-channel, single-rate finite impulse response filter with 37 taps. Two complete sets of coefficients are held on chip. Every incoming sample carries a bank-select bit, and that bit chooses which of the two sets computes the result for that sample. A dedicated write port reloads either set one word per clock while the filter keeps accepting and producing samples, so a new response can be staged in the idle set and switched in on a chosen sample boundary.

Samples enter and results leave over valid/ready streaming handshakes. A 2-bit error tag rides along with each sample and comes out with the matching result. The accumulator keeps full precision: 16-bit signed samples times 16-bit signed coefficients summed over 37 taps give a 38-bit result, with no rounding or saturation. The result register is the only pipeline stage. It buffers one result and stalls the input when the consumer holds off.

Coefficients are written in natural tap order. The first word of a load lands on tap 0, the tap that multiplies the newest sample. Each word arrives on a 19-bit bus, of which only the low 16 bits are used, as a signed value.

Top module: `dual_bank_fir`

## Requirements
- R1: The reset input is synchronous and active low. Reset clears the output valid flag, the sample history, both coefficient sets and the reload position, so the next write after reset goes to tap 0.
- R2: A sample is taken on a clock edge where `smp_valid` and `smp_ready` are both high. Its result shows on `res_data` with `res_valid` high right after that edge, unless the output is stalled.
- R3: While `res_valid` is high and `res_ready` is low, `res_data` and `res_err` hold their values, `res_valid` stays high and `smp_ready` is low.
- R4: A result equals the sum over k = 0..36 of coef[k] times x[n-k], where x[n] is the sample just taken. It is exact in 38-bit two's complement. Each coefficient is bits 15:0 of `ld_coef`, read as signed, and bits 18:16 are ignored.
- R5: `smp_bank` = 0 uses coefficient set 0 and `smp_bank` = 1 uses set 1, chosen separately for each sample taken.
- R6: Each clock edge with `ld_en` high writes `ld_coef` into the set chosen by `ld_bank` at the current reload position, and the position then moves up by one.
- R7: After a write to tap 36 the reload position wraps to 0, so the 38th write of an unbroken run replaces tap 0.
- R8: On any clock edge where `ld_bank` differs from its value at the previous edge, the reload position restarts at 0. A write on that edge goes to tap 0.
- R9: Writes to one set do not stall sample intake and do not change results computed from the other set. A write becomes visible to samples taken on later edges.
- R10: The `smp_err` value given with a sample appears on `res_err` together with that sample's result.
- R11: Right after reset, when no coefficients have been loaded yet, every result is zero.
- R12: Samples offered while `smp_ready` is low do not enter the history and do not affect any later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_data | input | 16 | Signed input sample |
| smp_valid | input | 1 | Input sample is valid |
| smp_ready | output | 1 | Filter can take a sample this cycle |
| smp_err | input | 2 | Error tag carried with the sample |
| smp_bank | input | 1 | Coefficient set used for this sample |
| ld_en | input | 1 | Coefficient write strobe, active high |
| ld_bank | input | 1 | Coefficient set that receives writes |
| ld_coef | input | 19 | Coefficient word; bits 15:0 used as signed |
| res_data | output | 38 | Full-precision signed result |
| res_valid | output | 1 | Result is valid |
| res_ready | input | 1 | Consumer can take the result |
| res_err | output | 2 | Error tag of the result |

## Verification
A result is due in the cycle right after the edge that takes its sample, because the result register is the only stage. A coefficient write affects only samples taken on later edges. The bench drives every input on the falling edge and notes whether `smp_ready` was high before the rising edge. It updates its own model at that rising edge and compares `res_data` and `res_err` one time unit after it. In the stall cycles the bench checks at the same point that the held result has not changed and that `smp_ready` is low. It then shows that the refused samples never reach a later sum.

// File: rtl/fir_pkg.sv
// Package: fir_pkg
// Shared definitions for the dual-bank FIR filter.
// Assumes exactly two coefficient sets, addressed by a single bit.
package fir_pkg;

    // Names of the two coefficient sets
    typedef enum logic {
        BANK_ZERO = 1'b0,
        BANK_ONE  = 1'b1
    } bank_sel_e;

    localparam int NUM_BANKS = 2;

endpackage

// File: rtl/fir_coef_store.sv
// Module: fir_coef_store
// Holds both coefficient sets and the shared reload position.
// A write lands at the current position of the chosen set; the position
// advances, wraps after the last tap, and restarts whenever the target set
// changes. A write is seen by readers from the next cycle on.
// Assumes TAPS >= 2 and BUS_W > COEF_W.
module fir_coef_store #(
    parameter int COEF_W = 16,
    parameter int BUS_W  = 19,
    parameter int TAPS   = 37
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          wr_en,
    input  logic                                          wr_bank,
    input  logic [BUS_W-1:0]                              wr_data,
    output logic [fir_pkg::NUM_BANKS*TAPS*COEF_W-1:0]     banks_flat
);
    localparam int PTR_W  = $clog2(TAPS);
    localparam int BANK_W = TAPS * COEF_W;

    logic [PTR_W-1:0] ptr_q;
    logic             last_bank_q;
    logic             bank_changed;
    logic [PTR_W-1:0] wr_idx;
    logic             wr_hi_unused;

    assign bank_changed = (wr_bank != last_bank_q);
    assign wr_idx       = bank_changed ? '0 : ptr_q;
    assign wr_hi_unused = ^wr_data[BUS_W-1:COEF_W];

    // Reload position: restart on a change of set, advance on a write, wrap at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q       <= '0;
            last_bank_q <= fir_pkg::BANK_ZERO;
        end else begin
            last_bank_q <= wr_bank;
            if (bank_changed) begin
                ptr_q <= wr_en ? PTR_W'(1) : '0;
            end else if (wr_en) begin
                ptr_q <= (ptr_q == PTR_W'(TAPS - 1)) ? '0 : ptr_q + PTR_W'(1);
            end
        end
    end

    for (genvar b = 0; b < fir_pkg::NUM_BANKS; b++) begin : g_bank
        logic [COEF_W-1:0] mem_q [TAPS];

        // Coefficient storage for one set: cleared on reset, written word by word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < TAPS; k++) mem_q[k] <= '0;
            end else if (wr_en && (wr_bank == 1'(b))) begin
                mem_q[wr_idx] <= wr_data[COEF_W-1:0];
            end
        end

        for (genvar k = 0; k < TAPS; k++) begin : g_out
            assign banks_flat[b*BANK_W + k*COEF_W +: COEF_W] = mem_q[k];
        end
    end

    // R6
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q < PTR_W'(TAPS));

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bank_changed && ptr_q != PTR_W'(TAPS - 1))
        |=> ptr_q == $past(ptr_q) + PTR_W'(1));

    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bank_changed && ptr_q == PTR_W'(TAPS - 1)) |=> ptr_q == '0);

    // R8
    switch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank_changed) |=> ptr_q == PTR_W'(1));

    // R8
    switch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && bank_changed) |=> ptr_q == '0);

endmodule

// File: rtl/fir_delay_line.sv
// Module: fir_delay_line
// Keeps the TAPS-1 previous samples, newest first. Shifts only when a
// sample is taken, so refused samples never enter the history.
// Assumes TAPS >= 2.
module fir_delay_line #(
    parameter int DATA_W = 16,
    parameter int TAPS   = 37
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             shift_en,
    input  logic [DATA_W-1:0]                din,
    output logic [(TAPS-1)*DATA_W-1:0]       hist_flat
);
    localparam int DEPTH = TAPS - 1;

    logic [DATA_W-1:0] hist_q [DEPTH];

    // History shift register: cleared on reset, advanced on each taken sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) hist_q[k] <= '0;
        end else if (shift_en) begin
            hist_q[0] <= din;
            for (int k = 1; k < DEPTH; k++) hist_q[k] <= hist_q[k-1];
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_flat
        assign hist_flat[k*DATA_W +: DATA_W] = hist_q[k];
    end

    // R12
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_flat));

    // R2
    hist_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_flat[DATA_W-1:0] == $past(din));

endmodule

// File: rtl/fir_mac.sv
// Module: fir_mac
// Combinational sum of products over all taps at full precision.
// Tap 0 multiplies the incoming sample, tap k the k-th previous one.
// Assumes ACC_W is wide enough for TAPS products with no overflow.
module fir_mac #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int TAPS   = 37,
    parameter int ACC_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
    input  logic [DATA_W-1:0]            din,
    input  logic [(TAPS-1)*DATA_W-1:0]   hist_flat,
    input  logic [TAPS*COEF_W-1:0]       coef_flat,
    output logic [ACC_W-1:0]             acc
);
    localparam int PROD_W = DATA_W + COEF_W;

    logic signed [PROD_W-1:0] prod [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        logic signed [DATA_W-1:0] x_k;
        logic signed [COEF_W-1:0] c_k;
        if (k == 0) begin : g_new
            assign x_k = din;
        end else begin : g_old
            assign x_k = hist_flat[(k-1)*DATA_W +: DATA_W];
        end
        assign c_k     = coef_flat[k*COEF_W +: COEF_W];
        assign prod[k] = PROD_W'(x_k * c_k);
    end

    // Adder tree written as a chain: sign-extend every product into the accumulator
    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) begin
            acc = acc + {{(ACC_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
        end
    end

endmodule

// File: rtl/dual_bank_fir.sv
// Module: dual_bank_fir
// Top level of the 37-tap FIR filter with two reloadable coefficient sets.
// Each sample picks its set; the other set can be rewritten meanwhile.
// One result register forms the single pipeline stage and a one-deep
// buffer; intake stalls while an unread result is held back.
// Assumes the consumer follows valid/ready rules on the result side.
module dual_bank_fir #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int BUS_W  = 19,
    parameter int TAPS   = 37,
    parameter int ERR_W  = 2,
    parameter int ACC_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              smp_valid,
    output logic              smp_ready,
    input  logic [ERR_W-1:0]  smp_err,
    input  logic              smp_bank,
    input  logic              ld_en,
    input  logic              ld_bank,
    input  logic [BUS_W-1:0]  ld_coef,
    output logic [ACC_W-1:0]  res_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [ERR_W-1:0]  res_err
);
    localparam int BANK_W = TAPS * COEF_W;

    logic [fir_pkg::NUM_BANKS*BANK_W-1:0] banks_flat;
    logic [BANK_W-1:0]                    coef_sel;
    logic [(TAPS-1)*DATA_W-1:0]           hist_flat;
    logic [ACC_W-1:0]                     acc;
    logic                                 take;

    assign smp_ready = !res_valid || res_ready;
    assign take      = smp_valid && smp_ready;
    assign coef_sel  = (smp_bank == fir_pkg::BANK_ONE)
                       ? banks_flat[BANK_W +: BANK_W]
                       : banks_flat[0 +: BANK_W];

    fir_coef_store #(
        .COEF_W (COEF_W),
        .BUS_W  (BUS_W),
        .TAPS   (TAPS)
    ) coef_store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ld_en),
        .wr_bank    (ld_bank),
        .wr_data    (ld_coef),
        .banks_flat (banks_flat)
    );

    fir_delay_line #(
        .DATA_W (DATA_W),
        .TAPS   (TAPS)
    ) delay_line_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (take),
        .din       (smp_data),
        .hist_flat (hist_flat)
    );

    fir_mac #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .TAPS   (TAPS),
        .ACC_W  (ACC_W)
    ) mac_i (
        .din       (smp_data),
        .hist_flat (hist_flat),
        .coef_flat (coef_sel),
        .acc       (acc)
    );

    // Result register: load on a taken sample, drop valid once the consumer reads it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_err   <= '0;
        end else if (take) begin
            res_valid <= 1'b1;
            res_data  <= acc;
            res_err   <= smp_err;
        end else if (res_ready) begin
            res_valid <= 1'b0;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !res_valid);

    // R2
    take_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> res_valid);

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready)
        |=> (res_valid && $stable(res_data) && $stable(res_err)));

    // R10
    err_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> res_err == $past(smp_err));

endmodule

// File: tb/dual_bank_fir_tb_top.sv
// Directed bench for dual_bank_fir. Inputs change on the falling edge;
// outputs are compared one time unit after the rising edge, against a
// model built from the requirements.
module dual_bank_fir_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TAPS       = 37;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] smp_data;
    logic        smp_valid;
    logic        smp_ready;
    logic [1:0]  smp_err;
    logic        smp_bank;
    logic        ld_en;
    logic        ld_bank;
    logic [18:0] ld_coef;
    logic [37:0] res_data;
    logic        res_valid;
    logic        res_ready;
    logic [1:0]  res_err;

    int checks   = 0;
    int failures = 0;

    // Model state
    longint coefm [2][TAPS];
    longint hist  [TAPS];
    int     bptr;
    bit     blast;
    bit     cur_wb;
    longint last_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_bank_fir dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_data  (smp_data),
        .smp_valid (smp_valid),
        .smp_ready (smp_ready),
        .smp_err   (smp_err),
        .smp_bank  (smp_bank),
        .ld_en     (ld_en),
        .ld_bank   (ld_bank),
        .ld_coef   (ld_coef),
        .res_data  (res_data),
        .res_valid (res_valid),
        .res_ready (res_ready),
        .res_err   (res_err)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint sx16(input logic [18:0] v);
        return longint'($signed(v[15:0]));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; smp_err = '0; smp_bank = 1'b0;
        ld_en = 1'b0; ld_bank = 1'b0; ld_coef = '0; res_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < 2; b++) for (int k = 0; k < TAPS; k++) coefm[b][k] = 0;
        for (int k = 0; k < TAPS; k++) hist[k] = 0;
        bptr = 0; blast = 1'b0; cur_wb = 1'b0;
    endtask

    // One clock: drive inputs, update model at the edge, check a taken sample's result
    task automatic step(input bit ds, input logic [15:0] x, input bit sb, input logic [1:0] se,
                        input bit dw, input bit wb, input logic [18:0] wv, input string tag);
        bit     tk;
        longint exp;
        @(negedge clk);
        smp_valid = ds; smp_data = x; smp_bank = sb; smp_err = se;
        ld_en = dw; ld_bank = wb; ld_coef = wv;
        #1 tk = ds && smp_ready;
        @(posedge clk);
        exp = 0;
        if (tk) begin
            for (int k = TAPS-1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = longint'($signed(x));
            for (int k = 0; k < TAPS; k++) exp += coefm[sb][k] * hist[k];
            last_exp = exp;
        end
        if (wb != blast) begin
            if (dw) begin coefm[wb][0] = sx16(wv); bptr = 1; end
            else bptr = 0;
        end else if (dw) begin
            coefm[wb][bptr] = sx16(wv);
            bptr = (bptr == TAPS-1) ? 0 : bptr + 1;
        end
        blast = wb;
        #1;
        if (tk) begin
            chk(res_valid == 1'b1, {tag, " R2 valid"}, res_valid, 1);
            chk(longint'($signed(res_data)) == exp, {tag, " data"}, longint'($signed(res_data)), exp);
            chk(res_err == se, {tag, " R10 err"}, res_err, se);
        end
    endtask

    task automatic send(input logic [15:0] x, input bit sb, input logic [1:0] se, input string tag);
        step(1'b1, x, sb, se, 1'b0, cur_wb, '0, tag);
    endtask

    task automatic wr(input bit b, input logic [18:0] v);
        cur_wb = b;
        step(1'b0, '0, 1'b0, 2'b00, 1'b1, b, v, "wr");
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, 2'b00, 1'b0, cur_wb, '0, "idle");
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk(res_valid == 1'b0, "R1 valid after reset", res_valid, 0);
        chk(smp_ready == 1'b1, "R2 ready after reset", smp_ready, 1);
    endtask

    task automatic t_zero_banks();
        for (int i = 0; i < 6; i++) begin
            send(16'(1000 * i - 2500), i[0], 2'b00, "R11");
            chk(res_data == '0, "R11 zero output", longint'($signed(res_data)), 0);
        end
    endtask

    task automatic t_load_filter();
        // upper three bus bits carry junk that must be ignored (R4)
        for (int k = 0; k < TAPS; k++) wr(1'b0, {3'b101, 16'(97 * k - 1500)});
        for (int i = 0; i < 45; i++) send(16'(i * 731 - 9000), 1'b0, 2'b00, "R4 R6 bank0");
    endtask

    task automatic t_bank_select();
        for (int k = 0; k < TAPS; k++) wr(1'b1, {3'b010, 16'(-211 * (k + 1))});
        for (int i = 0; i < 20; i++) send(16'(i * 1299 - 12000), i[0], 2'b00, "R5 alternate");
    endtask

    task automatic t_full_scale();
        for (int k = 0; k < TAPS; k++) wr(1'b0, 19'h0_8000);
        for (int i = 0; i < TAPS; i++) send(16'h8000, 1'b0, 2'b00, "R4 full scale");
        chk(longint'($signed(res_data)) == 64'd37 * 64'd1073741824, "R4 full scale sum",
            longint'($signed(res_data)), 64'd37 * 64'd1073741824);
    endtask

    task automatic t_wrap();
        for (int k = 0; k < TAPS + 3; k++) wr(1'b1, 19'(k * 13 + 1));
        for (int i = 0; i < 40; i++) send(16'(i * 17 - 300), 1'b1, 2'b00, "R7 wrap");
    endtask

    task automatic t_switch();
        for (int k = 0; k < 5; k++) wr(1'b1, 19'(500 + k));
        for (int k = 0; k < 2; k++) wr(1'b0, 19'(7 + k));
        for (int k = 0; k < 3; k++) wr(1'b1, 19'(900 + k));
        for (int i = 0; i < 40; i++) send(16'(i * 3 + 1), i[1], 2'b00, "R8 restart");
    endtask

    task automatic t_concurrent();
        cur_wb = 1'b1;
        for (int i = 0; i < 40; i++)
            step(1'b1, 16'(i * 555 - 7000), 1'b0, 2'b00, 1'b1, 1'b1, 19'(i * 41 - 800), "R9 concurrent");
        for (int i = 0; i < 40; i++) send(16'(i * 123 - 2000), 1'b1, 2'b00, "R9 new bank");
    endtask

    task automatic t_backpressure();
        logic [37:0] held;
        logic [1:0]  held_err;
        idle();
        res_ready = 1'b0;
        send(16'd4242, 1'b0, 2'b01, "R3 first");
        held = res_data; held_err = res_err;
        for (int i = 0; i < 3; i++) begin
            send(16'(30000 - i), 1'b1, 2'b10, "R12 refused");
            chk(smp_ready == 1'b0, "R3 ready low", smp_ready, 0);
            chk(res_valid == 1'b1, "R3 valid held", res_valid, 1);
            chk(res_data == held, "R3 data held", longint'($signed(res_data)), longint'($signed(held)));
            chk(res_err == held_err, "R3 err held", res_err, held_err);
        end
        res_ready = 1'b1;
        for (int i = 0; i < 3; i++) send(16'(i * 77 + 5), 1'b0, 2'b00, "R12 after stall");
    endtask

    task automatic t_err();
        for (int i = 0; i < 8; i++) send(16'(i * 311), i[0], 2'(i), "R10 tags");
    endtask

    task automatic t_reset_mid();
        wr(1'b0, 19'd99);
        wr(1'b0, 19'd98);
        do_reset();
        #1;
        chk(res_valid == 1'b0, "R1 valid cleared", res_valid, 0);
        wr(1'b0, 19'd5);
        send(16'd3, 1'b0, 2'b00, "R1 first tap after reset");
        chk(longint'($signed(res_data)) == 15, "R1 tap0 write", longint'($signed(res_data)), 15);
        send(16'd0, 1'b0, 2'b00, "R1 history cleared");
        chk(longint'($signed(res_data)) == 0, "R1 history cleared", longint'($signed(res_data)), 0);
    endtask

    initial begin
        t_reset();
        t_zero_banks();
        t_load_filter();
        t_bank_select();
        t_full_scale();
        t_wrap();
        t_switch();
        t_concurrent();
        t_backpressure();
        t_err();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule